// File: doc/BRIEF.md
# Idle-Count Gap Transmit Scheduler

This block sits between a frame source and a 64b/66b block encoder. Each clock carries one 64-bit block of eight character lanes. On every cycle the block decides whether that block carries frame data, idle characters, or four idles followed by a frame start in the upper half.

The gap between two frames is counted exactly in idle characters and has no variance. A frame may start only at lane 0 or at lane 4. The idles this forces beyond the programmed count are kept as a credit of 0 to 3 characters, and that credit is taken off the next gap, so the long-run average matches the programmed spacing.

An optional hidden-signalling mode takes one bit per gap from a serial valid/ready stream:
- A 1 lengthens the gap by a delta.
- A 0 shortens the gap by the same delta.
- With no bit on offer, the base gap is used.

Every gap is clamped to at least a minimum of 12 idles. Configuration is sampled only in the cycle a frame ends.

The controller is a three-state machine:
- OPEN: the gap is satisfied. The block sends idle blocks until a frame is ready, then starts it at lane 0 (transition OPEN->FRAME).
- FRAME: frame blocks pass through. The end marker moves the machine to GAP and loads the gap counter (transitions FRAME->GAP, and OPEN->GAP or GAP->GAP for a frame that ends in its start block).
- GAP: the block counts idles down eight per block.
  - With eight left, it sends a full idle block (GAP->OPEN).
  - With four left and a frame ready, it sends four idles plus a start in the upper half (GAP->FRAME).
  - With four left and no frame ready, it sends a full idle block (GAP->OPEN).

Top module: `ifg_sched`

## Requirements
- R1: After reset the block is in OPEN with zero credit. With no frame ready it drives sel_frame=0, sof=0, sof_hi=0, cov_rdy=0 and idle_cnt=8.
- R2: In OPEN, when frm_rdy is high, the same cycle carries the frame start at lane 0: sel_frame=1, sof=1, sof_hi=0, idle_cnt=0.
- R3: Once started, sel_frame stays high on every cycle up to and including the cycle where frm_end is high. The cycle after that end has sel_frame=0.
- R4: Every non-frame cycle has idle_cnt=8. A start in the upper half has sof_hi=1, sof=1, sel_frame=1 and idle_cnt=4. The idles between two frames equal the required count rounded up to a multiple of 4, unless the source stalls.
- R5: The required count is the gap value minus the credit. The credit is the rounding excess of the previous gap (0..3) and is 0 after reset.
- R6: With hidden mode on, cov_rdy is high exactly in the frame-end cycle. If cov_valid is high there, cov_bit=1 gives base+delta and cov_bit=0 gives base-delta.
- R7: With hidden mode on and cov_valid low at frame end, the gap value is the base.
- R8: The gap value, after any delta, is raised to 12 if it is smaller, so base-delta never underflows.
- R9: cfg_base, cfg_delta and cfg_cov_en are used only in a frame-end cycle. Changes during a gap affect only the next gap.
- R10: If no frame is ready when the count runs out, full idle blocks continue. The next frame starts at lane 0 once ready, and the credit keeps only the rounding excess.
- R11: With hidden mode off, cov_rdy stays low and the gap value is the base, whatever cov_valid and cov_bit do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | GAP_W | Base gap in idle characters |
| cfg_delta | input | GAP_W | Hidden-mode gap offset in idle characters |
| cfg_cov_en | input | 1 | Hidden-signalling mode enable |
| frm_rdy | input | 1 | Source has a frame ready to start |
| frm_end | input | 1 | Current frame block is the last one |
| cov_valid | input | 1 | A hidden bit is offered |
| cov_bit | input | 1 | Offered hidden bit |
| cov_rdy | output | 1 | Hidden bit taken this cycle |
| sel_frame | output | 1 | Block carries frame data; source advances |
| sof | output | 1 | Block carries the frame start |
| sof_hi | output | 1 | Start sits at lane 4; lanes 0-3 idle |
| idle_cnt | output | 4 | Idle characters sent in this block (0, 4 or 8) |

## Verification
A behavioural model counts idles owed per character and works out the credit when a frame actually starts, not when the gap is loaded. It is compared with every output on every cycle.

The scenarios and what each one separates:
- Gap values of 12, 13 and 30 tell apart starts at lane 0 and lane 4, and show whether the rounding credit carries forward.
- A base below the minimum exercises the clamp.
- Random hidden bits with valid gaps, and with some missing, check that a 1 lengthens and a 0 shortens the gap, and that a missing bit leaves the base.
- Toggling the base mid-gap checks that the value is sampled only at frame end.
- Random source stalls separate rounding excess from idles forced by the stall.
- The mode-off run checks that offered bits are ignored.

// File: rtl/ifg_pkg.sv
package ifg_pkg;
    localparam int LANES = 8;
    localparam int HALF  = LANES / 2;

    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_FRAME = 2'd1,
        ST_GAP   = 2'd2
    } ifg_state_e;
endpackage

// File: rtl/ifg_gap_calc.sv
module ifg_gap_calc #(
    parameter int GAP_W   = 16,
    parameter int MIN_IFG = 12,
    parameter int CW      = GAP_W + 3
) (
    input  logic [GAP_W-1:0] base,
    input  logic [GAP_W-1:0] delta,
    input  logic             cov_use,
    input  logic             cov_bit,
    input  logic [1:0]       credit,
    output logic [CW-1:0]    need_r,
    output logic [1:0]       credit_nxt
);
    localparam logic signed [CW-1:0] MIN_S = CW'(MIN_IFG);

    logic signed [CW-1:0] b_s, d_s, raw, clamped, need, rounded;

    always_comb begin
        b_s = signed'({3'b000, base});
        d_s = signed'({3'b000, delta});
        if (cov_use)
            raw = cov_bit ? (b_s + d_s) : (b_s - d_s);
        else
            raw = b_s;
        clamped    = (raw < MIN_S) ? MIN_S : raw;
        need       = clamped - signed'({{(CW-2){1'b0}}, credit});
        rounded    = (need + CW'(3)) & ~CW'(3);
        need_r     = rounded;
        credit_nxt = rounded[1:0] - need[1:0];
    end
endmodule

// File: rtl/ifg_gap_counter.sv
module ifg_gap_counter #(
    parameter int CW      = 19,
    parameter int MIN_IFG = 12,
    parameter int FULL    = 8,
    parameter int HALF    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          at_half,
    output logic          at_last
);
    logic [CW-1:0] rem;

    always_ff @(posedge clk) begin
        if (!rst_n)
            rem <= '0;
        else if (load)
            rem <= load_val;
        else if (dec)
            rem <= (rem > CW'(FULL)) ? rem - CW'(FULL) : '0;
    end

    assign at_half = (rem == CW'(HALF));
    assign at_last = (rem == CW'(FULL));

    // R5: loaded count is half-block aligned and never below minimum less credit
    p_load_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (rem[1:0] == 2'b00) && (rem >= CW'(MIN_IFG - 3)));

    // R4: load and count-down never coincide
    p_load_dec_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && dec));

    // R4: every count-down step shrinks the remainder
    p_dec_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && rem != '0) |=> rem < $past(rem));
endmodule

// File: rtl/ifg_sched.sv
module ifg_sched
    import ifg_pkg::*;
#(
    parameter int GAP_W   = 16,
    parameter int MIN_IFG = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GAP_W-1:0] cfg_base,
    input  logic [GAP_W-1:0] cfg_delta,
    input  logic             cfg_cov_en,
    input  logic             frm_rdy,
    input  logic             frm_end,
    input  logic             cov_valid,
    input  logic             cov_bit,
    output logic             cov_rdy,
    output logic             sel_frame,
    output logic             sof,
    output logic             sof_hi,
    output logic [3:0]       idle_cnt
);
    localparam int CW = GAP_W + 3;

    ifg_state_e    state_q, state_d;
    logic [1:0]    credit_q, credit_nxt;
    logic [CW-1:0] need_r;
    logic          load, dec, at_half, at_last, end_evt;

    ifg_gap_calc #(.GAP_W(GAP_W), .MIN_IFG(MIN_IFG), .CW(CW)) u_calc (
        .base       (cfg_base),
        .delta      (cfg_delta),
        .cov_use    (cfg_cov_en && cov_valid),
        .cov_bit    (cov_bit),
        .credit     (credit_q),
        .need_r     (need_r),
        .credit_nxt (credit_nxt)
    );

    ifg_gap_counter #(.CW(CW), .MIN_IFG(MIN_IFG), .FULL(LANES), .HALF(HALF)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (need_r),
        .dec      (dec),
        .at_half  (at_half),
        .at_last  (at_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_OPEN;
            credit_q <= 2'b00;
        end else begin
            state_q <= state_d;
            if (load)
                credit_q <= credit_nxt;
        end
    end

    always_comb begin
        state_d   = state_q;
        sel_frame = 1'b0;
        sof       = 1'b0;
        sof_hi    = 1'b0;
        idle_cnt  = 4'(LANES);
        dec       = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                if (frm_rdy) begin
                    sel_frame = 1'b1;
                    sof       = 1'b1;
                    idle_cnt  = 4'd0;
                    state_d   = ST_FRAME;
                end
            end
            ST_FRAME: begin
                sel_frame = 1'b1;
                idle_cnt  = 4'd0;
            end
            ST_GAP: begin
                if (at_half) begin
                    if (frm_rdy) begin
                        sel_frame = 1'b1;
                        sof       = 1'b1;
                        sof_hi    = 1'b1;
                        idle_cnt  = 4'(HALF);
                        state_d   = ST_FRAME;
                    end else begin
                        dec     = 1'b1;
                        state_d = ST_OPEN;
                    end
                end else begin
                    dec = 1'b1;
                    if (at_last)
                        state_d = ST_OPEN;
                end
            end
            default: state_d = ST_OPEN;
        endcase
        end_evt = sel_frame && frm_end;
        load    = end_evt;
        if (end_evt)
            state_d = ST_GAP;
        cov_rdy = cfg_cov_en && end_evt;
    end

    // R4: an upper-half start carries exactly four idles
    p_half_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sof_hi |-> (sof && sel_frame && idle_cnt == 4'(HALF)));

    // R4: a non-frame block is fully idle
    p_idle_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_frame |-> (idle_cnt == 4'(LANES)));

    // R3: a frame is not interrupted before its end marker
    p_frame_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_frame && !frm_end) |=> sel_frame);

    // R3: the block after a frame end is never frame data
    p_gap_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_frame && frm_end) |=> !sel_frame);

    // R6: hidden bit taken only in a frame-end block
    p_cov_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cov_rdy |-> (sel_frame && frm_end));

    // R11: mode off never takes a bit
    p_cov_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_cov_en |-> !cov_rdy);
endmodule

// File: tb/tb_ifg_sched.sv
`timescale 1ns/1ps
module tb_ifg_sched;
    localparam int GAP_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [GAP_W-1:0] cfg_base = '0, cfg_delta = '0;
    logic             cfg_cov_en = 1'b0, frm_rdy = 1'b0, frm_end = 1'b0;
    logic             cov_valid = 1'b0, cov_bit = 1'b0;
    logic             cov_rdy, sel_frame, sof, sof_hi;
    logic [3:0]       idle_cnt;

    ifg_sched #(.GAP_W(GAP_W), .MIN_IFG(12)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_delta(cfg_delta),
        .cfg_cov_en(cfg_cov_en), .frm_rdy(frm_rdy), .frm_end(frm_end),
        .cov_valid(cov_valid), .cov_bit(cov_bit), .cov_rdy(cov_rdy),
        .sel_frame(sel_frame), .sof(sof), .sof_hi(sof_hi), .idle_cnt(idle_cnt)
    );

    always #2.5 clk = ~clk;

    int n_vec = 0, n_bad = 0;
    int m_owed = 0, m_credit = 0;
    bit m_in_frame = 0;
    int src_left = 0, len_idx = 0;
    bit done = 0;

    task automatic chk(string tag, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // rdy_mode: 0 always ready, 1 random, 2 never; cov_mode: 0 none offered, 1 random
    task automatic step(string tag, int base, int delta, bit cen, int rdy_mode, int cov_mode);
        int e_idle, g;
        bit e_sel, e_sof, e_hi, e_cov;
        @(negedge clk);
        if (src_left == 0) begin
            src_left = 1 + ((len_idx * 3) % 5);
            len_idx++;
        end
        frm_rdy    = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : ($urandom_range(0, 2) == 0);
        frm_end    = (src_left == 1);
        cfg_base   = GAP_W'(base);
        cfg_delta  = GAP_W'(delta);
        cfg_cov_en = cen;
        cov_valid  = (cov_mode == 1) ? ($urandom_range(0, 3) != 0) : 1'b0;
        cov_bit    = $urandom_range(0, 1) == 1;
        #1;
        e_sel = 0; e_sof = 0; e_hi = 0; e_idle = 8;
        if (m_in_frame) begin
            e_sel = 1; e_idle = 0;
        end else if (m_owed == 0) begin
            if (frm_rdy) begin e_sel = 1; e_sof = 1; e_idle = 0; end
        end else if (m_owed <= 4) begin
            if (frm_rdy) begin e_sel = 1; e_sof = 1; e_hi = 1; e_idle = 4; end
        end
        e_cov = e_sel && frm_end && cen;
        chk(tag, "sel_frame", int'(sel_frame), int'(e_sel));
        chk(tag, "sof", int'(sof), int'(e_sof));
        chk(tag, "sof_hi", int'(sof_hi), int'(e_hi));
        chk(tag, "idle_cnt", int'(idle_cnt), e_idle);
        chk(tag, "cov_rdy", int'(cov_rdy), int'(e_cov));
        if (e_sel) begin
            if (e_hi) begin
                m_credit = 4 - m_owed;
                m_owed = 0;
            end
            if (frm_end) begin
                g = base;
                if (cen && cov_valid) g = cov_bit ? base + delta : base - delta;
                if (g < 12) g = 12;
                m_owed = g - m_credit;
                m_credit = 0;
                m_in_frame = 0;
            end else begin
                m_in_frame = 1;
            end
            src_left--;
        end else if (m_owed > 0) begin
            if (m_owed <= 4) begin m_credit = 4 - m_owed; m_owed = 0; end
            else if (m_owed <= 8) begin m_credit = 8 - m_owed; m_owed = 0; end
            else m_owed -= 8;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, nothing ready
        for (int i = 0; i < 4; i++) step("R1", 12, 0, 0, 2, 0);
        // R2 R3: back-to-back frames at minimum gap
        for (int i = 0; i < 60; i++) step("R2 R3", 12, 0, 0, 0, 0);
        // R4: gap with upper-half starts
        for (int i = 0; i < 80; i++) step("R4", 30, 0, 0, 0, 0);
        // R5: odd gap, credit carried
        for (int i = 0; i < 120; i++) step("R5", 13, 0, 0, 0, 0);
        // R8: base below minimum
        for (int i = 0; i < 60; i++) step("R8", 3, 0, 0, 0, 0);
        // R6: hidden bits modulate gaps
        for (int i = 0; i < 300; i++) step("R6", 40, 9, 1, 0, 1);
        // R7: mode on, no bit offered
        for (int i = 0; i < 100; i++) step("R7", 40, 8, 1, 0, 0);
        // R11: mode off, bits offered and ignored
        for (int i = 0; i < 100; i++) step("R11", 35, 8, 0, 0, 1);
        // R8: base minus delta below minimum
        for (int i = 0; i < 200; i++) step("R8", 20, 12, 1, 0, 1);
        // R9: base toggled during gaps
        for (int i = 0; i < 200; i++) step("R9", ((i / 7) % 2 == 1) ? 17 : 44, 0, 0, 0, 0);
        // R10: source stalls
        for (int i = 0; i < 300; i++) step("R10", 14, 0, 0, 1, 0);
        // R6: long gaps around the typical setting
        for (int i = 0; i < 2400; i++) step("R6", 3562, 128, 1, 0, 1);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule